// File: doc/BRIEF.md
# Hub Port Status Indicator Driver

This block drives one green and one amber status lamp for each downstream port of a hub. In automatic mode the lamps follow hardware status: green shows that a port is enabled, and amber shows an overcurrent fault. A fault overrides the enabled state, so a faulted port shows amber alone. In manual mode, software gives each port a 3-bit code. The code selects a steady colour, a blinking colour, or green and amber taking turns. All blinking ports share one phase, which a slow timebase tick advances.

Each lamp output can be set to sink or to source current, so a single polarity input supports both common-anode and common-cathode wiring. A 4-bit brightness value sets the fraction of clock cycles in which a lit lamp is actually driven. This dims the lamps to save power. The electrical design of the lamps and the storage of the settings lie outside the block.

Two small state machines are used. The mode machine has the states MODE_AUTO and MODE_MANUAL. It moves MODE_AUTO→MODE_MANUAL when `manual_sel` is high and MODE_MANUAL→MODE_AUTO when it is low. Reset puts it in MODE_AUTO. The blink machine has the states PH_DARK and PH_LIT. It moves PH_DARK→PH_LIT and PH_LIT→PH_DARK on the tick that completes a half period, and it resets to PH_DARK.

Top module: `hub_port_indicator`

## Requirements
- R1: In automatic mode a port's green lamp is lit exactly when its enable flag is high and its overcurrent flag is low.
- R2: In automatic mode a port's amber lamp is lit exactly when its overcurrent flag is high, whatever the enable flag is.
- R3: Reset selects automatic mode. A change of `manual_sel` reaches the lamp outputs two clock edges later. During the first of those edges the outputs still follow the old mode.
- R4: In manual mode each port's code sits at bits [3p+2:3p] of `manual_code`. Code 0 is off, 1 is steady green and 2 is steady amber. Codes 6 and 7 are off. The enable and overcurrent flags have no effect in manual mode.
- R5: Code 3 blinks green and code 4 blinks amber. Each blink is a 50% square wave whose half period is BLINK_TICKS timebase ticks. The phase starts dark after reset and does not advance while `tick` is low.
- R6: Code 5 lights green in the lit half of the blink and amber in the dark half, so exactly one of the two lamps is lit at any time.
- R7: All ports that blink do so in the same phase.
- R8: When `drive_low` is 0 a lit lamp drives 1. When it is 1 a lit lamp drives 0. The polarity applies combinationally, and during reset all lamps show dark at the selected polarity.
- R9: With brightness value d on `duty`, a lit lamp is driven in d of every 16 consecutive clocks for d from 0 to 14, and in all 16 for d = 15.
- R10: A change of the enable, overcurrent or code inputs reaches the outputs at the first clock edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase pulse that advances the blink phase |
| manual_sel | input | 1 | 1 selects manual mode, 0 selects automatic mode |
| port_en | input | NUM_PORTS | Per-port enabled flag |
| port_oc | input | NUM_PORTS | Per-port overcurrent flag |
| manual_code | input | 3*NUM_PORTS | Per-port manual codes, port p at bits [3p+2:3p] |
| drive_low | input | 1 | Polarity select: 1 means a lit lamp drives low |
| duty | input | DUTY_W | Brightness value |
| led_green | output | NUM_PORTS | Green lamp drive, one bit per port |
| led_amber | output | NUM_PORTS | Amber lamp drive, one bit per port |

## Verification
A change of enable, overcurrent or code reaches the lamps one clock after it is applied. A mode change takes two clocks. A polarity change shows at once. The bench therefore drives inputs on the falling edge and samples exactly one falling edge later for the flag sweeps. For the mode change it samples both after one edge and after two edges. Polarity is checked a short delay after the change. Brightness and blinking are checked by counting lit samples over full 16-cycle and 8-cycle windows, which makes the result independent of the counters' starting phase. A separate check confirms that the blink output holds still while no tick arrives.

// File: rtl/ind_pkg.sv
package ind_pkg;
    localparam int CODE_W = 3;

    typedef enum logic {
        MODE_AUTO   = 1'b0,
        MODE_MANUAL = 1'b1
    } ind_mode_e;

    typedef enum logic {
        PH_DARK = 1'b0,
        PH_LIT  = 1'b1
    } blink_ph_e;

    typedef enum logic [CODE_W-1:0] {
        CODE_OFF   = 3'd0,
        CODE_GRN   = 3'd1,
        CODE_AMB   = 3'd2,
        CODE_BLK_G = 3'd3,
        CODE_BLK_A = 3'd4,
        CODE_ALT   = 3'd5,
        CODE_RSV6  = 3'd6,
        CODE_RSV7  = 3'd7
    } man_code_e;
endpackage

// File: rtl/ind_mode_fsm.sv
module ind_mode_fsm
    import ind_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic manual_sel,
    output logic is_manual
);
    ind_mode_e state_q, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_AUTO;
        else        state_q <= state_nx;
    end

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            MODE_AUTO:   if (manual_sel)  state_nx = MODE_MANUAL;
            MODE_MANUAL: if (!manual_sel) state_nx = MODE_AUTO;
            default:     state_nx = MODE_AUTO;
        endcase
    end

    always_comb begin
        is_manual = (state_q == MODE_MANUAL);
    end

    // R3: the mode follows the select one edge later
    assert_mode_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
        manual_sel |=> is_manual);
    assert_mode_leave_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !manual_sel |=> !is_manual);
endmodule

// File: rtl/ind_blink_gen.sv
module ind_blink_gen
    import ind_pkg::*;
#(
    parameter int BLINK_TICKS = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    output logic blink_on
);
    localparam int CNT_W = (BLINK_TICKS > 1) ? $clog2(BLINK_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLINK_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wrap;
    blink_ph_e        ph_q, ph_nx;

    assign wrap = tick && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (wrap)  cnt_q <= '0;
        else if (tick)  cnt_q <= cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_DARK;
        else        ph_q <= ph_nx;
    end

    always_comb begin
        ph_nx = ph_q;
        unique case (ph_q)
            PH_DARK: if (wrap) ph_nx = PH_LIT;
            PH_LIT:  if (wrap) ph_nx = PH_DARK;
            default: ph_nx = PH_DARK;
        endcase
    end

    always_comb begin
        blink_on = (ph_q == PH_LIT);
    end

    // R5: no tick, no phase movement
    assert_phase_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(blink_on));
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/ind_pwm_gen.sv
module ind_pwm_gen #(
    parameter int DUTY_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DUTY_W-1:0] duty,
    output logic              pwm_on
);
    localparam logic [DUTY_W-1:0] FULL = '1;

    logic [DUTY_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    always_comb begin
        pwm_on = (duty == FULL) || (cnt_q < duty);
    end

    // R9: the counter advances by one every clock
    assert_cnt_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != FULL |=> cnt_q == $past(cnt_q) + 1'b1);
    assert_duty_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        duty == '0 |-> !pwm_on);
endmodule

// File: rtl/ind_port_map.sv
module ind_port_map
    import ind_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_manual,
    input  logic              en,
    input  logic              oc,
    input  logic [CODE_W-1:0] code,
    input  logic              blink_on,
    input  logic              pwm_on,
    output logic              lit_g,
    output logic              lit_a
);
    logic want_g, want_a;

    always_comb begin
        want_g = 1'b0;
        want_a = 1'b0;
        if (!is_manual) begin
            want_a = oc;
            want_g = en && !oc;
        end else begin
            unique case (man_code_e'(code))
                CODE_GRN:   want_g = 1'b1;
                CODE_AMB:   want_a = 1'b1;
                CODE_BLK_G: want_g = blink_on;
                CODE_BLK_A: want_a = blink_on;
                CODE_ALT: begin
                    want_g = blink_on;
                    want_a = !blink_on;
                end
                default: begin
                    want_g = 1'b0;
                    want_a = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lit_g <= 1'b0;
            lit_a <= 1'b0;
        end else begin
            lit_g <= want_g && pwm_on;
            lit_a <= want_a && pwm_on;
        end
    end

    // R2: a fault shows amber alone
    assert_oc_prio_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_manual && oc && pwm_on) |=> (lit_a && !lit_g));
    // R4: manual off keeps both dark whatever the flags
    assert_manual_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_manual && code == CODE_OFF) |=> (!lit_g && !lit_a));
    // R6: alternate never lights both
    assert_alt_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_manual && code == CODE_ALT) |=> !(lit_g && lit_a));
endmodule

// File: rtl/hub_port_indicator.sv
module hub_port_indicator
    import ind_pkg::*;
#(
    parameter int NUM_PORTS   = 4,
    parameter int BLINK_TICKS = 250,
    parameter int DUTY_W      = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic                        manual_sel,
    input  logic [NUM_PORTS-1:0]        port_en,
    input  logic [NUM_PORTS-1:0]        port_oc,
    input  logic [NUM_PORTS*CODE_W-1:0] manual_code,
    input  logic                        drive_low,
    input  logic [DUTY_W-1:0]           duty,
    output logic [NUM_PORTS-1:0]        led_green,
    output logic [NUM_PORTS-1:0]        led_amber
);
    logic                 is_manual;
    logic                 blink_on;
    logic                 pwm_on;
    logic [NUM_PORTS-1:0] lit_g, lit_a;

    ind_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .manual_sel (manual_sel),
        .is_manual  (is_manual)
    );

    ind_blink_gen #(.BLINK_TICKS(BLINK_TICKS)) u_blink (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .blink_on (blink_on)
    );

    ind_pwm_gen #(.DUTY_W(DUTY_W)) u_pwm (
        .clk    (clk),
        .rst_n  (rst_n),
        .duty   (duty),
        .pwm_on (pwm_on)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        ind_port_map u_map (
            .clk       (clk),
            .rst_n     (rst_n),
            .is_manual (is_manual),
            .en        (port_en[p]),
            .oc        (port_oc[p]),
            .code      (manual_code[p*CODE_W +: CODE_W]),
            .blink_on  (blink_on),
            .pwm_on    (pwm_on),
            .lit_g     (lit_g[p]),
            .lit_a     (lit_a[p])
        );
    end

    assign led_green = lit_g ^ {NUM_PORTS{drive_low}};
    assign led_amber = lit_a ^ {NUM_PORTS{drive_low}};

    // R8: dark level during reset is the inactive polarity
    always_comb begin
        if (!rst_n) begin
            assert_reset_dark_R8: assert (led_green == {NUM_PORTS{drive_low}}
                                          && led_amber == {NUM_PORTS{drive_low}});
        end
    end
endmodule

// File: tb/hub_port_indicator_bench.sv
`timescale 1ns/1ps
module hub_port_indicator_bench;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          manual_sel = 1'b0;
    logic [NP-1:0] port_en = '0;
    logic [NP-1:0] port_oc = '0;
    logic [3*NP-1:0] manual_code = '0;
    logic          drive_low = 1'b0;
    logic [3:0]    duty = 4'd15;
    logic [NP-1:0] led_green, led_amber;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    hub_port_indicator #(.NUM_PORTS(NP), .BLINK_TICKS(2), .DUTY_W(4)) u_hub_port_indicator (
        .clk(clk), .rst_n(rst_n), .tick(tick), .manual_sel(manual_sel),
        .port_en(port_en), .port_oc(port_oc), .manual_code(manual_code),
        .drive_low(drive_low), .duty(duty),
        .led_green(led_green), .led_amber(led_amber)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3*NP-1:0] all_codes(input logic [2:0] c);
        logic [3*NP-1:0] v;
        for (int p = 0; p < NP; p++) v[p*3 +: 3] = c;
        return v;
    endfunction

    function automatic logic [NP-1:0] gl();
        return led_green ^ {NP{drive_low}};
    endfunction

    function automatic logic [NP-1:0] al();
        return led_amber ^ {NP{drive_low}};
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [NP-1:0] exp_g, exp_a, snap;
        int cnt, cnt_a;
        bit ok;

        // reset state and polarity (R8, R3)
        wait_n(2);
        chk(led_green == 0 && led_amber == 0, "R8 reset dark high-active", int'({led_green, led_amber}), 0);
        drive_low = 1'b1;
        #1;
        chk(led_green == '1 && led_amber == '1, "R8 reset dark low-active", int'({led_green, led_amber}), 8'hFF);
        drive_low = 1'b0;
        wait_n(1);
        rst_n = 1'b1;
        port_en = '1;
        wait_n(1);
        chk(gl() == '1, "R3 automatic after reset", int'(gl()), 4'hF);

        // exhaustive automatic sweep, one edge latency (R1, R2, R10)
        for (int v = 0; v < 256; v++) begin
            port_en = v[3:0];
            port_oc = v[7:4];
            wait_n(1);
            exp_g = v[3:0] & ~v[7:4];
            exp_a = v[7:4];
            chk(gl() == exp_g, "R1/R10 auto green", int'(gl()), int'(exp_g));
            chk(al() == exp_a, "R2 auto amber", int'(al()), int'(exp_a));
        end

        // enter manual, steady codes and ignored flags (R4)
        manual_sel = 1'b1;
        manual_code = all_codes(3'd0);
        wait_n(3);
        for (int ci = 0; ci < 5; ci++) begin
            logic [2:0] c;
            c = (ci < 3) ? 3'(ci) : 3'(ci + 3);
            for (int f = 0; f < 2; f++) begin
                port_en = f[0] ? '1 : '0;
                port_oc = f[0] ? '1 : '0;
                manual_code = all_codes(c);
                wait_n(1);
                exp_g = (c == 3'd1) ? '1 : '0;
                exp_a = (c == 3'd2) ? '1 : '0;
                chk(gl() == exp_g && al() == exp_a, "R4 manual steady code",
                    int'({gl(), al()}), int'({exp_g, exp_a}));
            end
        end
        // mixed codes across ports: p0 off, p1 green, p2 amber, p3 code7 (R4)
        manual_code = {3'd7, 3'd2, 3'd1, 3'd0};
        wait_n(1);
        chk(gl() == 4'b0010 && al() == 4'b0100, "R4 per-port fields",
            int'({gl(), al()}), 8'h24);

        // leave manual: two edge latency (R3)
        manual_code = all_codes(3'd0);
        port_en = '1;
        port_oc = '0;
        wait_n(1);
        manual_sel = 1'b0;
        wait_n(1);
        chk(gl() == '0, "R3 old mode one edge after change", int'(gl()), 0);
        wait_n(1);
        chk(gl() == '1, "R3 auto two edges after change", int'(gl()), 4'hF);

        // blinking (R5, R7)
        manual_sel = 1'b1;
        tick = 1'b1;
        manual_code = all_codes(3'd3);
        wait_n(3);
        cnt = 0;
        ok = 1'b1;
        for (int k = 0; k < 8; k++) begin
            wait_n(1);
            if (gl()[0]) cnt++;
            if (!(gl() == '0 || gl() == '1) || al() != '0) ok = 1'b0;
        end
        chk(cnt == 4, "R5 blink green half", cnt, 4);
        chk(ok, "R7 ports blink in phase", int'(ok), 1);

        manual_code = all_codes(3'd4);
        wait_n(2);
        cnt = 0;
        ok = 1'b1;
        for (int k = 0; k < 8; k++) begin
            wait_n(1);
            if (al()[2]) cnt++;
            if (!(al() == '0 || al() == '1) || gl() != '0) ok = 1'b0;
        end
        chk(cnt == 4, "R5 blink amber half", cnt, 4);
        chk(ok, "R7 amber in phase", int'(ok), 1);

        // alternate (R6)
        manual_code = all_codes(3'd5);
        wait_n(2);
        cnt = 0;
        cnt_a = 0;
        ok = 1'b1;
        for (int k = 0; k < 8; k++) begin
            wait_n(1);
            if (gl()[1]) cnt++;
            if (al()[1]) cnt_a++;
            if ((gl() ^ al()) != '1) ok = 1'b0;
        end
        chk(ok, "R6 exactly one colour lit", int'(ok), 1);
        chk(cnt == 4 && cnt_a == 4, "R6 alternate halves", cnt * 16 + cnt_a, 8'h44);

        // no tick, no blink movement (R5)
        manual_code = all_codes(3'd3);
        tick = 1'b0;
        wait_n(2);
        snap = gl();
        ok = 1'b1;
        for (int k = 0; k < 20; k++) begin
            wait_n(1);
            if (gl() != snap) ok = 1'b0;
        end
        chk(ok, "R5 phase holds without tick", int'(ok), 1);

        // brightness sweep (R9)
        manual_sel = 1'b0;
        port_en = '1;
        port_oc = '0;
        wait_n(3);
        for (int d = 0; d < 16; d++) begin
            duty = 4'(d);
            wait_n(2);
            cnt = 0;
            for (int k = 0; k < 16; k++) begin
                wait_n(1);
                if (gl()[3]) cnt++;
            end
            chk(cnt == ((d == 15) ? 16 : d), "R9 lit cycles per 16", cnt, (d == 15) ? 16 : d);
        end
        duty = 4'd15;

        // polarity in operation (R8)
        port_en = 4'b0101;
        port_oc = 4'b0011;
        wait_n(2);
        drive_low = 1'b1;
        #1;
        chk(led_green == ~4'b0100 && led_amber == ~4'b0011, "R8 low-active drive",
            int'({led_green, led_amber}), int'({~4'b0100, ~4'b0011}));
        drive_low = 1'b0;
        #1;
        chk(led_green == 4'b0100 && led_amber == 4'b0011, "R8 high-active drive",
            int'({led_green, led_amber}), 8'h43);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule